// File: doc/BRIEF.md
# Periodic Program Counter Sampler

This block gives a debug probe a statistical picture of where a processor spends its time, without interrupting the processor. A programmable divider picks sampling points at a power-of-two spacing. At each point the block latches the address of the instruction that retires in that cycle. If nothing retires, it latches the address of the next instruction due to retire. The latched address is stored together with the current thread ID, the current address-space ID and a fresh-sample flag. A probe reads the packed word and pulses a read strobe, which retires the fresh flag so that the same sample is not counted twice.

While the processor sits in a wait state, the divider is frozen and the flag is held set, so the probe keeps seeing the address it is stalled on. A second capture source, enabled separately, latches the address of every instruction fetch that misses the instruction cache or is uncached. This source acts at once and ignores the divider. The address-space ID can be suppressed. A width output then tells the probe how many bits of the word are meaningful.

Top module: `pcs_sampler`

## Requirements
- R1: The sampling period is 2^(5+rate) cycles, where rate is the 3-bit rate field, so it spans 32 to 4096. When sampling is enabled, the first periodic capture lands on the period-th rising edge at which sampling is enabled, and later captures follow every period edges.
- R2: After reset the rate field is 7, which gives a period of 4096. The sample word is all zeros, which means the fresh flag is 0.
- R3: A periodic capture stores retireAddr when retireValid is high and nextAddr otherwise. It stores threadId and asid alongside the address.
- R4: Every capture sets the fresh flag, which is bit 32 of the word, on the edge of the capture.
- R5: While waitState is high and sampling is enabled, the period counter holds its value and no periodic capture occurs. The fresh flag is held at 1 even when the read strobe is pulsed, and the stored address does not change.
- R6: The word layout is address in bits [31:0], fresh in bit 32, thread ID in bits [40:33] and ASID in bits [48:41]. When noAsid is high, bits [48:41] read as zero and sampleWidth reads 41; otherwise sampleWidth reads 49.
- R7: When sampleEn, missCapEn and missValid are all high at an edge, missAddr is captured on that edge, whatever the counter value. If either enable is low, missValid has no effect.
- R8: When a miss capture and a periodic point fall on the same edge, the miss address is stored. The counter still restarts on every periodic point, and miss captures never restart it.
- R9: A read strobe clears the fresh flag on its edge, unless a capture happens on that same edge. In that case the flag stays 1.
- R10: A write of the rate field reloads the counter with the new period. The next periodic capture lands exactly one new period after the write edge.
- R11: While sampleEn is low, no capture of either kind occurs and the counter is held at its full period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| retireValid | input | 1 | An instruction retires this cycle |
| retireAddr | input | 32 | Address of the retiring instruction |
| nextAddr | input | 32 | Address of the next instruction to retire |
| waitState | input | 1 | Processor is halted in a wait state |
| threadId | input | 8 | Current thread-context ID |
| asid | input | 8 | Current address-space ID |
| missValid | input | 1 | Instruction fetch missed the cache or was uncached |
| missAddr | input | 32 | Address of that fetch |
| sampleEn | input | 1 | Sampling enable |
| missCapEn | input | 1 | Miss-capture enable |
| noAsid | input | 1 | Drop the ASID from the sample |
| rateWrEn | input | 1 | Write strobe for the rate field |
| rateWrData | input | 3 | New rate field value |
| readStrobe | input | 1 | Probe has consumed the sample |
| sampleWord | output | 49 | Packed sample: ASID, thread ID, fresh flag, address |
| sampleWidth | output | 8 | Number of meaningful sample bits |

## Verification
A corrupted period counter does not show up right away. It appears at the next capture, when the fresh flag rises on the wrong edge, so the bench checks the flag exactly one edge before and on the expected capture edge. With a 32-cycle period, any counting fault shows within one period. A wrong choice of address source or a wrong priority shows in the address field on the capture edge itself. Faulty fresh-flag bookkeeping shows one edge after a read strobe, or throughout a wait state.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef struct packed {
    logic capPeriodic;
    logic capMiss;
    logic setFresh;
    logic clearFresh;
  } pcs_strobe_t;
endpackage

// File: rtl/pcs_ctrl.sv
module pcs_ctrl
  import pcs_pkg::*;
#(
  parameter int RATE_W    = 3,
  parameter int MIN_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleEn,
  input  logic              missCapEn,
  input  logic              missValid,
  input  logic              waitState,
  input  logic              readStrobe,
  input  logic              rateWrEn,
  input  logic [RATE_W-1:0] rateWrData,
  output pcs_strobe_t       strobe
);
  localparam int MAX_RATE = (1 << RATE_W) - 1;
  localparam int CNT_W    = MIN_SHIFT + MAX_RATE;

  logic [RATE_W-1:0] rateQ;
  logic [CNT_W-1:0]  countQ;
  logic              atPoint;
  logic              missHit;

  function automatic logic [CNT_W-1:0] periodM1(input logic [RATE_W-1:0] r);
    logic [RATE_W-1:0] sh;
    sh = RATE_W'(MAX_RATE) - r;
    return {CNT_W{1'b1}} >> sh;
  endfunction

  assign atPoint = sampleEn & ~waitState & ~rateWrEn & (countQ == '0);
  assign missHit = sampleEn & missCapEn & missValid;

  always_comb begin
    strobe.capMiss     = missHit;
    strobe.capPeriodic = atPoint & ~missHit;
    strobe.setFresh    = missHit | atPoint | (sampleEn & waitState);
    strobe.clearFresh  = readStrobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateQ  <= RATE_W'(MAX_RATE);
      countQ <= periodM1(RATE_W'(MAX_RATE));
    end else if (rateWrEn) begin
      rateQ  <= rateWrData;
      countQ <= periodM1(rateWrData);
    end else if (!sampleEn) begin
      countQ <= periodM1(rateQ);
    end else if (!waitState) begin
      if (countQ == '0) countQ <= periodM1(rateQ);
      else              countQ <= countQ - 1'b1;
    end
  end

  // R1: the counter never exceeds the current period
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    countQ <= periodM1(rateQ));

  // R5: the counter is frozen during a wait state
  assert_wait_freeze_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && waitState && !rateWrEn) |=> $stable(countQ));

  // R10: a rate write is taken into the field
  assert_rate_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    rateWrEn |=> (rateQ == $past(rateWrData)));

  // R11: no capture strobe while disabled
  assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |-> !(strobe.capMiss || strobe.capPeriodic));
endmodule

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int TID_W  = 8,
  parameter int ASID_W = 8,
  localparam int WORD_W = ADDR_W + 1 + TID_W + ASID_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcs_strobe_t       strobe,
  input  logic              retireValid,
  input  logic [ADDR_W-1:0] retireAddr,
  input  logic [ADDR_W-1:0] nextAddr,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic [TID_W-1:0]  threadId,
  input  logic [ASID_W-1:0] asid,
  input  logic              noAsid,
  output logic [WORD_W-1:0] sampleWord,
  output logic [7:0]        sampleWidth
);
  logic [ADDR_W-1:0] addrQ;
  logic [TID_W-1:0]  tidQ;
  logic [ASID_W-1:0] asidQ;
  logic              freshQ;
  logic [ADDR_W-1:0] periodicAddr;
  logic              anyCap;

  assign periodicAddr = retireValid ? retireAddr : nextAddr;
  assign anyCap       = strobe.capMiss | strobe.capPeriodic;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      tidQ   <= '0;
      asidQ  <= '0;
      freshQ <= 1'b0;
    end else begin
      if (anyCap) begin
        addrQ <= strobe.capMiss ? missAddr : periodicAddr;
        tidQ  <= threadId;
        asidQ <= asid;
      end
      if (strobe.setFresh)        freshQ <= 1'b1;
      else if (strobe.clearFresh) freshQ <= 1'b0;
    end
  end

  assign sampleWord  = {(noAsid ? {ASID_W{1'b0}} : asidQ), tidQ, freshQ, addrQ};
  assign sampleWidth = noAsid ? 8'(WORD_W - ASID_W) : 8'(WORD_W);

  // R8: at most one capture source per edge
  assert_one_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.capMiss, strobe.capPeriodic}));

  // R4: a capture leaves the fresh flag set
  assert_fresh_on_cap_R4: assert property (@(posedge clk) disable iff (!rstN)
    anyCap |=> freshQ);

  // R7: a miss capture stores the miss address
  assert_miss_addr_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capMiss |=> (addrQ == $past(missAddr)));

  // R9: a read with nothing setting the flag clears it
  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearFresh && !strobe.setFresh) |=> !freshQ);
endmodule

// File: rtl/pcs_sampler.sv
module pcs_sampler
  import pcs_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int TID_W     = 8,
  parameter int ASID_W    = 8,
  parameter int RATE_W    = 3,
  parameter int MIN_SHIFT = 5,
  localparam int WORD_W   = ADDR_W + 1 + TID_W + ASID_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retireValid,
  input  logic [ADDR_W-1:0] retireAddr,
  input  logic [ADDR_W-1:0] nextAddr,
  input  logic              waitState,
  input  logic [TID_W-1:0]  threadId,
  input  logic [ASID_W-1:0] asid,
  input  logic              missValid,
  input  logic [ADDR_W-1:0] missAddr,
  input  logic              sampleEn,
  input  logic              missCapEn,
  input  logic              noAsid,
  input  logic              rateWrEn,
  input  logic [RATE_W-1:0] rateWrData,
  input  logic              readStrobe,
  output logic [WORD_W-1:0] sampleWord,
  output logic [7:0]        sampleWidth
);
  pcs_strobe_t strobe;

  pcs_ctrl #(.RATE_W(RATE_W), .MIN_SHIFT(MIN_SHIFT)) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .missCapEn(missCapEn),
    .missValid(missValid), .waitState(waitState), .readStrobe(readStrobe),
    .rateWrEn(rateWrEn), .rateWrData(rateWrData), .strobe(strobe)
  );

  pcs_datapath #(.ADDR_W(ADDR_W), .TID_W(TID_W), .ASID_W(ASID_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .retireValid(retireValid),
    .retireAddr(retireAddr), .nextAddr(nextAddr), .missAddr(missAddr),
    .threadId(threadId), .asid(asid), .noAsid(noAsid),
    .sampleWord(sampleWord), .sampleWidth(sampleWidth)
  );

  // R6: a suppressed ASID never reaches the word
  assert_asid_hidden_R6: assert property (@(posedge clk) disable iff (!rstN)
    noAsid |-> (sampleWord[WORD_W-1 -: ASID_W] == '0 && sampleWidth == 8'(WORD_W - ASID_W)));
endmodule

// File: tb/pcs_sampler_tb.sv
module pcs_sampler_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        retireValid = 1'b0;
  logic [31:0] retireAddr = '0;
  logic [31:0] nextAddr = '0;
  logic        waitState = 1'b0;
  logic [7:0]  threadId = '0;
  logic [7:0]  asid = '0;
  logic        missValid = 1'b0;
  logic [31:0] missAddr = '0;
  logic        sampleEn = 1'b0;
  logic        missCapEn = 1'b0;
  logic        noAsid = 1'b0;
  logic        rateWrEn = 1'b0;
  logic [2:0]  rateWrData = '0;
  logic        readStrobe = 1'b0;
  logic [48:0] sampleWord;
  logic [7:0]  sampleWidth;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pcs_sampler u_dut (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .retireAddr(retireAddr),
    .nextAddr(nextAddr), .waitState(waitState), .threadId(threadId), .asid(asid),
    .missValid(missValid), .missAddr(missAddr), .sampleEn(sampleEn),
    .missCapEn(missCapEn), .noAsid(noAsid), .rateWrEn(rateWrEn),
    .rateWrData(rateWrData), .readStrobe(readStrobe),
    .sampleWord(sampleWord), .sampleWidth(sampleWidth)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic fresh();
    return sampleWord[32];
  endfunction

  task automatic clearFresh();
    readStrobe = 1'b1; tick(1); readStrobe = 1'b0;
  endtask

  task automatic t_reset();
    check("R2 word zero", 64'(sampleWord), 64'h0);
    check("R6 full width", 64'(sampleWidth), 64'd49);
  endtask

  task automatic t_defaultPeriod();
    retireValid = 1'b1; retireAddr = 32'h1000_0040; nextAddr = 32'h1000_0044;
    threadId = 8'h03; asid = 8'h5A;
    sampleEn = 1'b1;
    tick(4095);
    check("R2 no capture before 4096", 64'(fresh()), 64'd0);
    tick(1);
    check("R1 R3 capture at 4096", 64'(sampleWord), 64'({8'h5A, 8'h03, 1'b1, 32'h1000_0040}));
  endtask

  task automatic t_read();
    clearFresh();
    check("R9 read clears fresh", 64'(fresh()), 64'd0);
  endtask

  task automatic t_rate();
    retireValid = 1'b0; nextAddr = 32'h2000_0100;
    rateWrEn = 1'b1; rateWrData = 3'd0; tick(1); rateWrEn = 1'b0;
    tick(31);
    check("R10 no capture before new period", 64'(fresh()), 64'd0);
    tick(1);
    check("R10 capture one period after write", 64'(fresh()), 64'd1);
    check("R3 next address when nothing retires", 64'(sampleWord[31:0]), 64'h2000_0100);
    clearFresh();
    tick(30);
    check("R1 periodic repeat not early", 64'(fresh()), 64'd0);
    tick(1);
    check("R1 periodic repeat", 64'(fresh()), 64'd1);
  endtask

  task automatic t_wait();
    waitState = 1'b1; retireValid = 1'b1; retireAddr = 32'h3000_0008; readStrobe = 1'b1;
    tick(100);
    check("R5 fresh held in wait", 64'(fresh()), 64'd1);
    check("R5 address held in wait", 64'(sampleWord[31:0]), 64'h2000_0100);
    waitState = 1'b0;
    tick(1); readStrobe = 1'b0;
    check("R9 read after wait clears", 64'(fresh()), 64'd0);
    tick(30);
    check("R5 counter resumed not early", 64'(fresh()), 64'd0);
    tick(1);
    check("R5 counter resumed from frozen value", 64'(sampleWord[31:0]), 64'h3000_0008);
    check("R4 fresh after capture", 64'(fresh()), 64'd1);
  endtask

  task automatic t_miss();
    rateWrEn = 1'b1; rateWrData = 3'd7; readStrobe = 1'b1; tick(1);
    rateWrEn = 1'b0; readStrobe = 1'b0;
    missCapEn = 1'b1; missValid = 1'b1; missAddr = 32'h4000_0010; tick(1); missValid = 1'b0;
    check("R7 miss captured at once", 64'(sampleWord[31:0]), 64'h4000_0010);
    check("R4 fresh after miss", 64'(fresh()), 64'd1);
    clearFresh();
    missCapEn = 1'b0; missValid = 1'b1; missAddr = 32'h4000_0020; tick(1); missValid = 1'b0;
    check("R7 miss ignored without enable", 64'(sampleWord[31:0]), 64'h4000_0010);
    check("R7 fresh untouched without enable", 64'(fresh()), 64'd0);
    missCapEn = 1'b1; sampleEn = 1'b0; missValid = 1'b1; tick(1); missValid = 1'b0;
    check("R11 miss ignored while disabled", 64'(sampleWord[31:0]), 64'h4000_0010);
    sampleEn = 1'b1;
  endtask

  task automatic t_collide();
    retireAddr = 32'h5000_0000;
    rateWrEn = 1'b1; rateWrData = 3'd0; readStrobe = 1'b1; tick(1);
    rateWrEn = 1'b0; readStrobe = 1'b0;
    tick(31);
    check("R8 no capture before point", 64'(fresh()), 64'd0);
    missValid = 1'b1; missAddr = 32'h5000_0ABC; tick(1); missValid = 1'b0;
    check("R8 miss wins collision", 64'(sampleWord[31:0]), 64'h5000_0ABC);
    clearFresh();
    tick(14);
    missValid = 1'b1; missAddr = 32'h5000_0DEF; tick(1); missValid = 1'b0;
    check("R8 mid-period miss", 64'(sampleWord[31:0]), 64'h5000_0DEF);
    clearFresh();
    tick(14);
    check("R8 miss did not restart counter early", 64'(fresh()), 64'd0);
    tick(1);
    check("R8 periodic on original schedule", 64'(sampleWord[31:0]), 64'h5000_0000);
  endtask

  task automatic t_readCapture();
    readStrobe = 1'b1; missValid = 1'b1; missAddr = 32'h6000_0004; tick(1);
    readStrobe = 1'b0; missValid = 1'b0;
    check("R9 capture beats read", 64'(fresh()), 64'd1);
  endtask

  task automatic t_noAsid();
    noAsid = 1'b1; #1;
    check("R6 asid bits zero", 64'(sampleWord[48:41]), 64'h0);
    check("R6 reduced width", 64'(sampleWidth), 64'd41);
    check("R6 thread id intact", 64'(sampleWord[40:33]), 64'h03);
    noAsid = 1'b0; #1;
    check("R6 asid restored", 64'(sampleWord[48:41]), 64'h5A);
  endtask

  task automatic t_disable();
    missCapEn = 1'b0;
    sampleEn = 1'b0; readStrobe = 1'b1; tick(1); readStrobe = 1'b0;
    tick(100);
    check("R11 no capture while disabled", 64'(fresh()), 64'd0);
    retireAddr = 32'h7000_0000;
    sampleEn = 1'b1;
    tick(31);
    check("R11 full period after enable", 64'(fresh()), 64'd0);
    tick(1);
    check("R11 capture after enable", 64'(sampleWord[31:0]), 64'h7000_0000);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    t_reset();
    t_defaultPeriod();
    t_read();
    t_rate();
    t_wait();
    t_miss();
    t_collide();
    t_readCapture();
    t_noAsid();
    t_disable();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule